// File: doc/BRIEF.md
# Wide Register Sub-word Address Decoder

This block turns CPU bus requests into access strobes for a register file in which some registers are wider than the CPU data bus. Each request has a valid bit, a byte address and a write flag. The strobes it drives are registered, so each one is a single-cycle pulse in the cycle after the request.

Most registers are normal registers. Each occupies one bus-width slot and gets one strobe. This includes a fixed group of consecutive registers and an arrayed group placed at a base address plus index times stride. A wide register is split into bus-width sub-words. Each sub-word has its own address and its own strobe, at consecutive bus-width steps from the register's base.

Field logic inside a wide register often needs to know whether it was touched at all. For that, the block also drives one strobe per field. A field strobe is high when any sub-word that holds a bit of that field is accessed. The write flag is passed alongside the strobes, so downstream storage can tell a read from a write.

Top module: `wide_subword_decoder`

## Requirements
- R1: With synchronous active-high reset, or when no valid request was presented in the previous cycle, every strobe and `dec_wr` is low.
- R2: Normal register i (0 to 2) strobes one cycle after a valid request to byte address 0x00 + 2*i.
- R3: Array element k (0 to 3) strobes one cycle after a valid request to byte address 0x10 + 4*k.
- R4: Each wide register is 64 bits on a 16-bit bus, so it has 4 sub-words. Sub-word s of wide register w strobes on `wide_stb[4*w+s]` one cycle after a valid request to 0x20 + 16*w + 2*s.
- R5: `fld_stb[5*w+f]` is the OR of wide register w's sub-word strobes from index lsb/16 to msb/16 of field f. The fields are, as [msb:lsb]: f0 [7:0], f1 [31:12], f2 [35:32], f3 [63:40], f4 [58:50].
- R6: At most one register or sub-word strobe is high in any cycle.
- R7: A valid request to an address that matches no slot raises no strobe. This covers gaps, addresses past the map, and byte addresses that are not multiples of the bus width in bytes.
- R8: `dec_wr` is high exactly in the cycle after a valid request that had `req_wr` set, whether or not the address hit.
- R9: Back-to-back requests each produce their own one-cycle strobe. No strobe is held past the cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | Request is a write |
| req_addr | input | 8 | Request byte address |
| norm_stb | output | 3 | Normal register strobes |
| arr_stb | output | 4 | Arrayed register strobes |
| wide_stb | output | 8 | Sub-word strobes, index 4*register+sub-word |
| fld_stb | output | 10 | Reduced field strobes, index 5*register+field |
| dec_wr | output | 1 | Write flag aligned with the strobes |

## Verification
A wrong base or step inside the decoder shows up at the ports in the cycle after a request: either the expected strobe stays silent or a neighbouring strobe fires. Misaligned and gap addresses are swept to expose comparisons that are too loose. A wrong field mask shows up as a field strobe that differs from the OR of its sub-words when a single sub-word is hit. Because every output is a registered pulse, a stuck or held register is visible one cycle later, on the next idle or differing request.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    // Request address width (byte addressing)
    localparam int REQ_AW       = 8;

    // Default geometry
    localparam int BUS_W_DEF    = 16;
    localparam int WIDE_W_DEF   = 64;

    // Default map
    localparam int NORM_BASE_DEF   = 'h00;
    localparam int NORM_CNT_DEF    = 3;
    localparam int ARR_BASE_DEF    = 'h10;
    localparam int ARR_CNT_DEF     = 4;
    localparam int ARR_STRIDE_DEF  = 4;
    localparam int WIDE_BASE_DEF   = 'h20;
    localparam int WIDE_CNT_DEF    = 2;
    localparam int WIDE_STRIDE_DEF = 16;

    // Field layout shared by every wide register
    localparam int FLD_CNT = 5;
    localparam int FLD_LSB [FLD_CNT] = '{0, 12, 32, 40, 50};
    localparam int FLD_MSB [FLD_CNT] = '{7, 31, 35, 63, 58};

    // Upper bound on sub-words per wide register
    localparam int MAX_SUB = 32;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [REQ_AW-1:0] addr;
    } wsd_req_t;

    // Mask of sub-word indices that a field [msb:lsb] touches
    function automatic logic [MAX_SUB-1:0] sub_mask(input int lsb, input int msb, input int aw);
        logic [MAX_SUB-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_SUB; i++) begin
            m[i] = (i >= lsb / aw) && (i <= msb / aw);
        end
        return m;
    endfunction

endpackage

// File: rtl/wsd_match.sv
module wsd_match #(
    parameter int          AW   = 8,
    parameter int unsigned BASE = 0
) (
    input  logic          req_vld,
    input  logic [AW-1:0] req_addr,
    output logic          hit
);
    localparam logic [AW-1:0] SLOT = AW'(BASE);

    // Exact byte compare: low address bits must match the slot as well
    assign hit = req_vld && (req_addr == SLOT);
endmodule

// File: rtl/wsd_subword_bank.sv
module wsd_subword_bank #(
    parameter int          AW     = 8,
    parameter int          BUS_W  = 16,
    parameter int          WIDE_W = 64,
    parameter int unsigned BASE   = 0
) (
    input  logic                      req_vld,
    input  logic [AW-1:0]             req_addr,
    output logic [WIDE_W/BUS_W-1:0]   sub_hit
);
    localparam int SUBW = WIDE_W / BUS_W;
    localparam int STEP = BUS_W / 8;

    for (genvar s = 0; s < SUBW; s++) begin : g_sub
        wsd_match #(
            .AW   (AW),
            .BASE (BASE + s * STEP)
        ) u_match (
            .req_vld  (req_vld),
            .req_addr (req_addr),
            .hit      (sub_hit[s])
        );
    end
endmodule

// File: rtl/wsd_field_reduce.sv
module wsd_field_reduce #(
    parameter int SUBW  = 4,
    parameter int N_FLD = wsd_pkg::FLD_CNT,
    parameter int BUS_W = 16
) (
    input  logic [SUBW-1:0]  sub_stb,
    output logic [N_FLD-1:0] fld_stb
);
    for (genvar f = 0; f < N_FLD; f++) begin : g_fld
        localparam logic [wsd_pkg::MAX_SUB-1:0] FM =
            wsd_pkg::sub_mask(wsd_pkg::FLD_LSB[f], wsd_pkg::FLD_MSB[f], BUS_W);
        assign fld_stb[f] = |(sub_stb & FM[SUBW-1:0]);
    end
endmodule

// File: rtl/wide_subword_decoder.sv
module wide_subword_decoder
    import wsd_pkg::*;
#(
    parameter int BUS_W       = BUS_W_DEF,
    parameter int WIDE_W      = WIDE_W_DEF,
    parameter int NORM_BASE   = NORM_BASE_DEF,
    parameter int NORM_CNT    = NORM_CNT_DEF,
    parameter int ARR_BASE    = ARR_BASE_DEF,
    parameter int ARR_CNT     = ARR_CNT_DEF,
    parameter int ARR_STRIDE  = ARR_STRIDE_DEF,
    parameter int WIDE_BASE   = WIDE_BASE_DEF,
    parameter int WIDE_CNT    = WIDE_CNT_DEF,
    parameter int WIDE_STRIDE = WIDE_STRIDE_DEF,
    parameter int N_FLD       = FLD_CNT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_vld,
    input  logic                        req_wr,
    input  logic [REQ_AW-1:0]           req_addr,
    output logic [NORM_CNT-1:0]         norm_stb,
    output logic [ARR_CNT-1:0]          arr_stb,
    output logic [WIDE_CNT*(WIDE_W/BUS_W)-1:0] wide_stb,
    output logic [WIDE_CNT*N_FLD-1:0]   fld_stb,
    output logic                        dec_wr
);
    localparam int SUBW      = WIDE_W / BUS_W;
    localparam int BUS_BYTES = BUS_W / 8;
    localparam int N_WSTB    = WIDE_CNT * SUBW;
    localparam int N_ALL     = NORM_CNT + ARR_CNT + N_WSTB;
    localparam logic [REQ_AW-1:0] LOW_MASK = REQ_AW'(BUS_BYTES - 1);

    wsd_req_t req;
    assign req = '{vld: req_vld, wr: req_wr, addr: req_addr};

    logic [NORM_CNT-1:0] norm_hit;
    logic [ARR_CNT-1:0]  arr_hit;
    logic [N_WSTB-1:0]   wide_hit;

    // Normal registers at consecutive bus-width slots
    for (genvar i = 0; i < NORM_CNT; i++) begin : g_norm
        wsd_match #(
            .AW   (REQ_AW),
            .BASE (NORM_BASE + i * BUS_BYTES)
        ) u_match (
            .req_vld  (req.vld),
            .req_addr (req.addr),
            .hit      (norm_hit[i])
        );
    end

    // Arrayed registers: base plus index times stride
    for (genvar k = 0; k < ARR_CNT; k++) begin : g_arr
        wsd_match #(
            .AW   (REQ_AW),
            .BASE (ARR_BASE + k * ARR_STRIDE)
        ) u_match (
            .req_vld  (req.vld),
            .req_addr (req.addr),
            .hit      (arr_hit[k])
        );
    end

    // Wide registers: one bank of sub-word compares each
    for (genvar w = 0; w < WIDE_CNT; w++) begin : g_wide
        wsd_subword_bank #(
            .AW     (REQ_AW),
            .BUS_W  (BUS_W),
            .WIDE_W (WIDE_W),
            .BASE   (WIDE_BASE + w * WIDE_STRIDE)
        ) u_bank (
            .req_vld  (req.vld),
            .req_addr (req.addr),
            .sub_hit  (wide_hit[w*SUBW +: SUBW])
        );
    end

    // Output registers
    logic [NORM_CNT-1:0] norm_q;
    logic [ARR_CNT-1:0]  arr_q;
    logic [N_WSTB-1:0]   wide_q;
    logic                wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            norm_q <= '0;
            arr_q  <= '0;
            wide_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            norm_q <= norm_hit;
            arr_q  <= arr_hit;
            wide_q <= wide_hit;
            wr_q   <= req.vld & req.wr;
        end
    end

    // Field strobes reduced from the registered sub-word strobes
    for (genvar w = 0; w < WIDE_CNT; w++) begin : g_fred
        wsd_field_reduce #(
            .SUBW  (SUBW),
            .N_FLD (N_FLD),
            .BUS_W (BUS_W)
        ) u_reduce (
            .sub_stb (wide_q[w*SUBW +: SUBW]),
            .fld_stb (fld_stb[w*N_FLD +: N_FLD])
        );
    end

    assign norm_stb = norm_q;
    assign arr_stb  = arr_q;
    assign wide_stb = wide_q;
    assign dec_wr   = wr_q;

    logic [N_ALL-1:0] all_stb;
    assign all_stb = {norm_q, arr_q, wide_q};

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(req_vld) |-> (all_stb == '0 && fld_stb == '0 && !dec_wr)); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_stb)); // R6

    AST_FIELD_NEEDS_SUB: assert property (@(posedge clk) disable iff (rst)
        (|fld_stb) |-> (|wide_stb)); // R5

    AST_MISALIGNED_MISS: assert property (@(posedge clk) disable iff (rst)
        $past(req_vld && ((req_addr & LOW_MASK) != '0)) |-> (all_stb == '0)); // R7

    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        dec_wr |-> $past(req_vld && req_wr)); // R8

    AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (|all_stb) |-> $past(req_vld)); // R9

endmodule

// File: tb/wide_subword_decoder_tb.sv
module wide_subword_decoder_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       req_vld;
    logic       req_wr;
    logic [7:0] req_addr;
    logic [2:0] norm_stb;
    logic [3:0] arr_stb;
    logic [7:0] wide_stb;
    logic [9:0] fld_stb;
    logic       dec_wr;

    wide_subword_decoder u_dut (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .norm_stb (norm_stb),
        .arr_stb  (arr_stb),
        .wide_stb (wide_stb),
        .fld_stb  (fld_stb),
        .dec_wr   (dec_wr)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [25:0] exp_now;
    string       exp_tag;

    int fl_lsb [5] = '{0, 12, 32, 40, 50};
    int fl_msb [5] = '{7, 31, 35, 63, 58};

    // Behavioural model: {norm, arr, wide, fld, wr}
    function automatic logic [25:0] model(input logic v, input logic w, input logic [7:0] a);
        logic [2:0] n  = '0;
        logic [3:0] r  = '0;
        logic [7:0] ws = '0;
        logic [9:0] f  = '0;
        if (v) begin
            for (int i = 0; i < 3; i++) if (int'(a) == 2*i) n[i] = 1'b1;
            for (int k = 0; k < 4; k++) if (int'(a) == 'h10 + 4*k) r[k] = 1'b1;
            for (int g = 0; g < 2; g++)
                for (int s = 0; s < 4; s++)
                    if (int'(a) == 'h20 + 16*g + 2*s) ws[g*4+s] = 1'b1;
        end
        for (int g = 0; g < 2; g++)
            for (int fi = 0; fi < 5; fi++)
                for (int s = fl_lsb[fi]/16; s <= fl_msb[fi]/16; s++)
                    if (ws[g*4+s]) f[g*5+fi] = 1'b1;
        return {n, r, ws, f, v & w};
    endfunction

    task automatic check();
        logic [25:0] got;
        got = {norm_stb, arr_stb, wide_stb, fld_stb, dec_wr};
        n_vec++;
        if (got !== exp_now) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", exp_tag, got, exp_now);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [7:0] a, input string tag);
        @(negedge clk);
        check();
        req_vld  = v;
        req_wr   = w;
        req_addr = a;
        exp_now  = model(v, w, a);
        exp_tag  = tag;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        req_vld  = 1'b0;
        req_wr   = 1'b0;
        req_addr = 8'h00;
        exp_now  = '0;
        exp_tag  = "R1 reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        check();
        rst = 1'b0;

        // R1: idle with a mapped-looking address
        step(1'b0, 1'b1, 8'h20, "R1 idle");
        step(1'b0, 1'b0, 8'h00, "R1 idle");
        // R2 normal registers, reads then writes (R8)
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'(2*i), "R2 normal read");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'(2*i), "R8 normal write");
        // R3 array elements and the gaps between them (R7)
        for (int k = 0; k < 4; k++) step(1'b1, k[0], 8'('h10 + 4*k), "R3 array");
        step(1'b1, 1'b0, 8'h12, "R7 array gap");
        step(1'b1, 1'b1, 8'h1E, "R7 array gap write");
        // R4/R5 every sub-word of both wide registers
        for (int g = 0; g < 2; g++)
            for (int s = 0; s < 4; s++)
                step(1'b1, 1'b0, 8'('h20 + 16*g + 2*s), "R4 R5 subword");
        // R7 odd and out-of-map addresses
        step(1'b1, 1'b0, 8'h21, "R7 odd byte");
        step(1'b1, 1'b0, 8'h28, "R7 past wide0");
        step(1'b1, 1'b1, 8'hFF, "R7 top of space");
        // R9 back-to-back same and differing slots, then idle
        step(1'b1, 1'b0, 8'h26, "R9 burst");
        step(1'b1, 1'b0, 8'h26, "R9 burst");
        step(1'b1, 1'b1, 8'h32, "R9 burst");
        step(1'b0, 1'b0, 8'h32, "R9 release");
        // R6/R7 full address sweep
        for (int a = 0; a < 256; a++)
            step(1'b1, a[1], 8'(a), (model(1'b1, 1'b0, 8'(a)) == '0) ? "R7 sweep" : "R6 sweep");
        step(1'b0, 1'b0, 8'h00, "R6 sweep tail");
        step(1'b0, 1'b0, 8'h00, "R1 final idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule